// File: doc/BRIEF.md
# Color-Tagged Branch Squash Stage

This block is the execute-side squash logic of an in-order pipeline. It removes wrong-path instructions after a taken jump without any flush wires to the earlier stages. Each instruction carries a one-bit path color. The fetch side stamps that color from its own register, and the execute side keeps a second color register. An instruction whose color differs from the execute color was fetched down an abandoned path. It still flows to write-back, but as an inert no-operation.

A taken jump that executes normally does three things. It flips the execute color, issues a one-cycle redirect with its target, and causes the fetch color to flip on the following clock edge. Every instruction already in flight then carries the stale color and is squashed as it arrives. No counting is needed. Instructions with a matching color are dispatched to their operation. The arithmetic here is only a small stand-in for a real ALU.

Top module: `color_squash_stage`

## Requirements
- R1: While reset is held, and in the first cycle after it, the execute color, the fetch color, `out_valid_o` and `redirect_valid_o` are all 0.
- R2: An instruction accepted with a color equal to the execute color produces its result on the output one clock edge later, with `out_valid_o`=1, `out_squashed_o`=0 and its own write-back code (0 none, 1 accumulator, 2 memory).
- R3: An instruction whose color differs from the execute color leaves one edge later with `out_valid_o`=1, `out_squashed_o`=1, write-back code 0 and result 0.
- R4: A jump (op code 4) marked taken with a matching color raises `redirect_valid_o` for exactly one cycle, carrying its target on `redirect_addr_o`, and complements the execute color on the same edge.
- R5: The fetch color complements on the clock edge that follows a cycle in which `redirect_valid_o` is 1, and on no other edge.
- R6: A taken jump whose color does not match raises no redirect and leaves both colors unchanged.
- R7: A jump marked not taken raises no redirect and leaves both colors unchanged.
- R8: A cycle with `in_valid_i`=0 yields `out_valid_o`=0, write-back code 0, and no color change.
- R9: Op codes 0 to 3 give, in order: operand A, A+B modulo 2^DATA_W, A AND B, A XOR B. A jump gives result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction present this cycle |
| in_color_i | input | 1 | Path color stamped at fetch |
| in_op_i | input | 3 | Operation code |
| in_taken_i | input | 1 | Jump resolved as taken |
| in_src_a_i | input | DATA_W | Operand A |
| in_src_b_i | input | DATA_W | Operand B |
| in_target_i | input | ADDR_W | Jump target |
| in_wb_i | input | 2 | Requested write-back code |
| out_valid_o | output | 1 | Instruction leaving toward write-back |
| out_squashed_o | output | 1 | Leaving instruction was converted to a no-op |
| out_result_o | output | DATA_W | Result |
| out_wb_o | output | 2 | Write-back code after squash |
| redirect_valid_o | output | 1 | Fetch redirect pulse |
| redirect_addr_o | output | ADDR_W | Redirect target |
| exec_color_o | output | 1 | Execute-side color |
| fetch_color_o | output | 1 | Fetch-side color for new instructions |

## Verification
The fetch color flips on the edge after a redirect. That is the same edge on which the first wrong-path instruction behind the jump reaches execute and must be squashed. The bench provokes this by sending a stale-color instruction immediately after a taken jump. It then checks, at the same sample point, that the squashed output and the new fetch color both appear. A taken jump placed directly in that wrong-path slot also shows that squashing and jump resolution in one cycle never produce a redirect.

// File: rtl/color_squash_pkg.sv
package color_squash_pkg;
  localparam int OP_W = 3;
  localparam int WB_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_MOV = 3'd0,
    OP_ADD = 3'd1,
    OP_AND = 3'd2,
    OP_XOR = 3'd3,
    OP_JMP = 3'd4
  } op_e;

  typedef enum logic [WB_W-1:0] {
    WB_NONE = 2'd0,
    WB_ACC  = 2'd1,
    WB_MEM  = 2'd2
  } wb_e;
endpackage

// File: rtl/fetch_color_reg.sv
module fetch_color_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic redirect_i,
  output logic color_o
);
  logic color_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) color_q <= 1'b0;
    else if (redirect_i) color_q <= ~color_q;
  end

  assign color_o = color_q;

  a_r5_fetch_flips_after_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> (color_q != $past(color_q)));
  a_r5_fetch_holds_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_i |=> $stable(color_q));
endmodule

// File: rtl/exec_color_ctrl.sv
module exec_color_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              color_i,
  input  logic              is_jump_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              squash_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              color_o
);
  logic              color_q;
  logic              redirect_q;
  logic [ADDR_W-1:0] addr_q;
  logic              fire;

  assign squash_o = valid_i & (color_i != color_q);
  // only a live, taken jump moves the path
  assign fire     = valid_i & ~squash_o & is_jump_i & taken_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      color_q    <= 1'b0;
      redirect_q <= 1'b0;
      addr_q     <= '0;
    end else begin
      redirect_q <= fire;
      if (fire) begin
        color_q <= ~color_q;
        addr_q  <= target_i;
      end
    end
  end

  assign redirect_o      = redirect_q;
  assign redirect_addr_o = addr_q;
  assign color_o         = color_q;

  a_r4_color_change_has_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(color_q) |-> redirect_q);
  a_r4_redirect_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_q |=> !redirect_q || $past(valid_i && is_jump_i));
endmodule

// File: rtl/exec_dispatch.sv
module exec_dispatch
  import color_squash_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              squash_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WB_W-1:0]   wb_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              out_valid_o,
  output logic              out_squashed_o,
  output logic [DATA_W-1:0] out_result_o,
  output logic [WB_W-1:0]   out_wb_o
);
  logic [DATA_W-1:0] alu_res;
  logic              live;

  assign live = valid_i & ~squash_i;

  always_comb begin
    unique case (op_e'(op_i))
      OP_MOV:  alu_res = src_a_i;
      OP_ADD:  alu_res = src_a_i + src_b_i;
      OP_AND:  alu_res = src_a_i & src_b_i;
      OP_XOR:  alu_res = src_a_i ^ src_b_i;
      default: alu_res = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o    <= 1'b0;
      out_squashed_o <= 1'b0;
      out_result_o   <= '0;
      out_wb_o       <= WB_NONE;
    end else begin
      out_valid_o    <= valid_i;
      out_squashed_o <= squash_i;
      out_result_o   <= live ? alu_res : '0;
      out_wb_o       <= live ? wb_i : WB_NONE;
    end
  end

  a_r8_idle_emits_nothing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !out_valid_o && (out_wb_o == WB_NONE));
endmodule

// File: rtl/color_squash_stage.sv
module color_squash_stage
  import color_squash_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_color_i,
  input  logic [2:0]        in_op_i,
  input  logic              in_taken_i,
  input  logic [DATA_W-1:0] in_src_a_i,
  input  logic [DATA_W-1:0] in_src_b_i,
  input  logic [ADDR_W-1:0] in_target_i,
  input  logic [1:0]        in_wb_i,
  output logic              out_valid_o,
  output logic              out_squashed_o,
  output logic [DATA_W-1:0] out_result_o,
  output logic [1:0]        out_wb_o,
  output logic              redirect_valid_o,
  output logic [ADDR_W-1:0] redirect_addr_o,
  output logic              exec_color_o,
  output logic              fetch_color_o
);
  logic squash;
  logic is_jump;

  assign is_jump = (op_e'(in_op_i) == OP_JMP);

  exec_color_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .valid_i        (in_valid_i),
    .color_i        (in_color_i),
    .is_jump_i      (is_jump),
    .taken_i        (in_taken_i),
    .target_i       (in_target_i),
    .squash_o       (squash),
    .redirect_o     (redirect_valid_o),
    .redirect_addr_o(redirect_addr_o),
    .color_o        (exec_color_o)
  );

  exec_dispatch #(.DATA_W(DATA_W)) u_disp (
    .clk_i, .rst_ni,
    .valid_i       (in_valid_i),
    .squash_i      (squash),
    .op_i          (in_op_i),
    .wb_i          (in_wb_i),
    .src_a_i       (in_src_a_i),
    .src_b_i       (in_src_b_i),
    .out_valid_o   (out_valid_o),
    .out_squashed_o(out_squashed_o),
    .out_result_o  (out_result_o),
    .out_wb_o      (out_wb_o)
  );

  fetch_color_reg u_fetch (
    .clk_i, .rst_ni,
    .redirect_i(redirect_valid_o),
    .color_o   (fetch_color_o)
  );

  a_r3_squashed_is_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_squashed_o |-> (out_wb_o == WB_NONE) && (out_result_o == '0));
  a_r6_squash_never_redirects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_squashed_o |-> !redirect_valid_o);
  a_r7_not_taken_holds_color: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_jump && !in_taken_i) |=> !redirect_valid_o && $stable(exec_color_o));
endmodule

// File: tb/color_squash_stage_bench.sv
module color_squash_stage_bench;
  typedef struct packed {
    logic        v;
    logic        c;
    logic [2:0]  op;
    logic        tk;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] tgt;
    logic [1:0]  wb;
    logic        e_v;
    logic        e_sq;
    logic [7:0]  e_res;
    logic [1:0]  e_wb;
    logic        e_red;
    logic        e_ec;
    logic        e_fc;
  } vec_t;

  localparam int N = 13;
  // R2/R9 ops, R4 jump, R3/R5 wrong-path slot, R6 squashed jump, R7 not taken, R8 idle
  localparam vec_t VECS [N] = '{
    '{1'b1,1'b0,3'd0,1'b0,8'h5A,8'h00,16'h0000,2'd1, 1'b1,1'b0,8'h5A,2'd1,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,3'd1,1'b0,8'hF0,8'h20,16'h0000,2'd1, 1'b1,1'b0,8'h10,2'd1,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,3'd2,1'b0,8'hCC,8'h0F,16'h0000,2'd2, 1'b1,1'b0,8'h0C,2'd2,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,3'd3,1'b0,8'hFF,8'h0F,16'h0000,2'd1, 1'b1,1'b0,8'hF0,2'd1,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,3'd4,1'b1,8'h00,8'h00,16'h1234,2'd0, 1'b1,1'b0,8'h00,2'd0,1'b1,1'b1,1'b0},
    '{1'b1,1'b0,3'd1,1'b0,8'h01,8'h01,16'h0000,2'd1, 1'b1,1'b1,8'h00,2'd0,1'b0,1'b1,1'b1},
    '{1'b1,1'b0,3'd4,1'b1,8'h00,8'h00,16'h9999,2'd0, 1'b1,1'b1,8'h00,2'd0,1'b0,1'b1,1'b1},
    '{1'b1,1'b1,3'd0,1'b0,8'h77,8'h00,16'h0000,2'd2, 1'b1,1'b0,8'h77,2'd2,1'b0,1'b1,1'b1},
    '{1'b1,1'b1,3'd4,1'b0,8'h00,8'h00,16'h4444,2'd0, 1'b1,1'b0,8'h00,2'd0,1'b0,1'b1,1'b1},
    '{1'b0,1'b1,3'd1,1'b0,8'h11,8'h22,16'h0000,2'd1, 1'b0,1'b0,8'h00,2'd0,1'b0,1'b1,1'b1},
    '{1'b1,1'b1,3'd4,1'b1,8'h00,8'h00,16'hABCD,2'd0, 1'b1,1'b0,8'h00,2'd0,1'b1,1'b0,1'b1},
    '{1'b1,1'b1,3'd3,1'b0,8'h0F,8'hF0,16'h0000,2'd2, 1'b1,1'b1,8'h00,2'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,3'd0,1'b0,8'h01,8'h00,16'h0000,2'd1, 1'b1,1'b0,8'h01,2'd1,1'b0,1'b0,1'b0}
  };
  localparam logic [15:0] RED_ADDR [N] = '{16'h0,16'h0,16'h0,16'h0,16'h1234,16'h0,16'h0,
                                           16'h0,16'h0,16'h0,16'hABCD,16'h0,16'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_color = 1'b0, in_taken = 1'b0;
  logic [2:0]  in_op = '0;
  logic [7:0]  in_a = '0, in_b = '0;
  logic [15:0] in_tgt = '0;
  logic [1:0]  in_wb = '0;
  logic out_valid, out_sq, red_v, ec, fc;
  logic [7:0]  out_res;
  logic [1:0]  out_wb;
  logic [15:0] red_a;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  color_squash_stage u_color_squash_stage (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_color_i(in_color), .in_op_i(in_op), .in_taken_i(in_taken),
    .in_src_a_i(in_a), .in_src_b_i(in_b), .in_target_i(in_tgt), .in_wb_i(in_wb),
    .out_valid_o(out_valid), .out_squashed_o(out_sq), .out_result_o(out_res), .out_wb_o(out_wb),
    .redirect_valid_o(red_v), .redirect_addr_o(red_a),
    .exec_color_o(ec), .fetch_color_o(fc)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "exec color in reset", {15'd0, ec}, 16'd0);
    chk("R1", "fetch color in reset", {15'd0, fc}, 16'd0);
    chk("R1", "out valid in reset", {15'd0, out_valid}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "redirect after reset", {15'd0, red_v}, 16'd0);

    for (int i = 0; i < N; i++) begin
      in_valid = VECS[i].v;  in_color = VECS[i].c; in_op = VECS[i].op;
      in_taken = VECS[i].tk; in_a = VECS[i].a;     in_b = VECS[i].b;
      in_tgt = VECS[i].tgt;  in_wb = VECS[i].wb;
      @(negedge clk);
      chk("R2/R8", $sformatf("v%0d valid", i), {15'd0, out_valid}, {15'd0, VECS[i].e_v});
      chk("R3", $sformatf("v%0d squashed", i), {15'd0, out_sq}, {15'd0, VECS[i].e_sq});
      chk("R9", $sformatf("v%0d result", i), {8'd0, out_res}, {8'd0, VECS[i].e_res});
      chk("R2", $sformatf("v%0d wb", i), {14'd0, out_wb}, {14'd0, VECS[i].e_wb});
      chk("R4/R6/R7", $sformatf("v%0d redirect", i), {15'd0, red_v}, {15'd0, VECS[i].e_red});
      if (VECS[i].e_red) chk("R4", $sformatf("v%0d target", i), red_a, RED_ADDR[i]);
      chk("R4", $sformatf("v%0d exec color", i), {15'd0, ec}, {15'd0, VECS[i].e_ec});
      chk("R5", $sformatf("v%0d fetch color", i), {15'd0, fc}, {15'd0, VECS[i].e_fc});
    end

    // R4 redirect drops after one cycle, R8 idle keeps colors
    in_valid = 1'b0;
    @(negedge clk);
    chk("R4", "redirect one cycle", {15'd0, red_v}, 16'd0);
    chk("R8", "idle output", {15'd0, out_valid}, 16'd0);

    // R1 mid-run reset after driving colors to 1
    in_valid = 1'b1; in_color = 1'b0; in_op = 3'd4; in_taken = 1'b1; in_tgt = 16'h0042;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R5", "fetch color set before reset", {15'd0, fc}, 16'd1);
    rst_n = 1'b0;
    #1;
    chk("R1", "exec color async reset", {15'd0, ec}, 16'd0);
    chk("R1", "fetch color async reset", {15'd0, fc}, 16'd0);
    chk("R1", "out valid async reset", {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule